// File: doc/BRIEF.md
# Stack-Chained Functional Unit Cell

This block is one cell of a coarse-grain array placed in the execute stage of a stack-based processor. In a single processor cycle it evaluates a chain of dependent operations. The cell takes two operands, as a stack machine would pop them, and hands them to a front stage. That stage offers an ALU, a shifter, a multiplier and a load path. Six simple-operation stages follow it. Each of them takes the running result as its first operand and a per-stage extra operand, or a small immediate, as its second. The outputs are registered, so results appear one clock after the inputs.

The front stage holds the cell's only multiplier. A multiply requested in a later stage is not executed in this cell. The value that reaches that stage is carried unchanged to the output, and a pending flag tells the controller to start the next cell with the multiply. The tail of the cell has two units. A branch unit tests the final value. A three-operand store unit forms an array-store request: a base and a value come in on ports, and the index is the chained result. Both units are held off while a multiply is pending.

Top module: `scell_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, valid_o, mul_pend_o, br_taken_o and st_valid_o are cleared, and result_o, st_addr_o and st_data_o become zero.
- R2: Each output is registered and reflects the inputs of the previous rising edge. valid_o equals the previous valid_i. When valid_i was low, mul_pend_o, br_taken_o and st_valid_o are low.
- R3: The front stage combines opnd_a_i with a second operand. That operand is opnd_b_i, or the zero-extended 8-bit immediate when the stage's immediate-select bit is set. Opcodes: 0 add, 1 subtract (a-b), 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right, 8 multiply (low 32 bits), 9 load (result is ld_data_i). Opcodes 10 to 15 give the first operand unchanged.
- R4: Chain stage k (1 to 6) takes the result of stage k-1 as its first operand. Its second operand is extra operand k, bits [32k-1:32(k-1)] of ext_i, or the stage's zero-extended immediate. Opcodes 0 to 7 act as in R3. Opcode 9 and opcodes 10 to 15 give the first operand unchanged.
- R5: Shift amounts are the low 5 bits of the second operand.
- R6: A stage whose pass bit is set outputs its first operand unchanged, whatever its opcode. For the front stage that operand is opnd_a_i.
- R7: If the first chain stage with opcode 8 and a clear pass bit is stage k, then result_o is the value entering stage k, all later stages are ignored, and mul_pend_o is 1. If no such stage exists, mul_pend_o is 0.
- R8: br_taken_o is 1 when the input was valid, no multiply is pending, and the final result meets the branch condition. Condition codes: 0 never, 1 equal to zero, 2 not zero, 3 negative (bit 31 set).
- R9: st_valid_o is 1 when the input was valid, the store enable was set and no multiply is pending. st_addr_o is st_base_i plus the final result, and st_data_o is st_value_i.
- R10: Configuration layout. Bit 0 is store enable and bits [2:1] are the branch condition. Stage s (0 = front) occupies bits [3+14s+13 : 3+14s]. Within a stage field: opcode at [13:10], pass at 9, immediate-select at 8, immediate at [7:0]. The word is 101 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Inputs carry an operation this cycle |
| cfg_i | input | 101 | Cell configuration word |
| opnd_a_i | input | 32 | First initial operand |
| opnd_b_i | input | 32 | Second initial operand |
| ext_i | input | 192 | Extra operands for chain stages 1 to 6, stage 1 lowest |
| ld_data_i | input | 32 | Value returned for a front-stage load |
| st_base_i | input | 32 | Array base for the tail store |
| st_value_i | input | 32 | Value for the tail store |
| valid_o | output | 1 | Registered valid |
| result_o | output | 32 | Chained result |
| mul_pend_o | output | 1 | Multiply deferred to the next cell |
| br_taken_o | output | 1 | Branch condition met |
| st_valid_o | output | 1 | Store request |
| st_addr_o | output | 32 | Store address |
| st_data_o | output | 32 | Store data |

## Verification
The assertions take three things for granted. The configuration word is stable for the cycle in which valid_i is high. Reset is held across at least one rising edge before the first operation. The extra operands need no particular relationship to one another, so properties on the flags depend on the configuration alone. The stimulus meets these conditions: every input is driven on the falling edge, reset is held for several edges at the start, and each configuration is built from the field layout of R10. A sweep places every front opcode against every chain opcode at every chain position, and randomized configurations fill the remaining stages.

// File: rtl/scell_pkg.sv
// Shared parameters, opcode values and configuration layout for the
// stack-chained cell. Assumes a single cell width across the array.
package scell_pkg;
    parameter int unsigned WORD_W    = 32;
    parameter int unsigned CHAIN_LEN = 6;
    parameter int unsigned IMM_W     = 8;
    parameter int unsigned OP_W      = 4;

    localparam int unsigned STAGES  = CHAIN_LEN + 1;
    localparam int unsigned SHAMT_W = $clog2(WORD_W);
    localparam int unsigned EXT_W   = CHAIN_LEN * WORD_W;

    localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
    localparam logic [OP_W-1:0] OP_SUB  = 4'd1;
    localparam logic [OP_W-1:0] OP_AND  = 4'd2;
    localparam logic [OP_W-1:0] OP_OR   = 4'd3;
    localparam logic [OP_W-1:0] OP_XOR  = 4'd4;
    localparam logic [OP_W-1:0] OP_SHL  = 4'd5;
    localparam logic [OP_W-1:0] OP_SHR  = 4'd6;
    localparam logic [OP_W-1:0] OP_SRA  = 4'd7;
    localparam logic [OP_W-1:0] OP_MUL  = 4'd8;
    localparam logic [OP_W-1:0] OP_LOAD = 4'd9;

    localparam logic [1:0] BR_NEVER = 2'd0;
    localparam logic [1:0] BR_EQZ   = 2'd1;
    localparam logic [1:0] BR_NEZ   = 2'd2;
    localparam logic [1:0] BR_NEG   = 2'd3;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic             pass;
        logic             b_imm;
        logic [IMM_W-1:0] imm;
    } stg_cfg_t;

    typedef struct packed {
        stg_cfg_t [STAGES-1:0] stg;
        logic [1:0]            br;
        logic                  st_en;
    } cell_cfg_t;

    localparam int unsigned CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/scell_op.sv
// One simple functional unit: ALU and shifter, with an optional multiplier
// and load path chosen by parameter. Purely combinational; unknown opcodes
// return the first operand.
module scell_op
    import scell_pkg::*;
#(
    parameter bit ALLOW_MUL  = 1'b0,
    parameter bit ALLOW_LOAD = 1'b0
) (
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] ld,
    output logic [WORD_W-1:0] y
);
    logic [SHAMT_W-1:0] shamt;
    logic [WORD_W-1:0]  prod;
    logic [WORD_W-1:0]  ldv;

    assign shamt = b[SHAMT_W-1:0];
    assign ldv   = ALLOW_LOAD ? ld : a;

    // the one multiplier of the cell exists only where requested
    generate
        if (ALLOW_MUL) begin : g_mul
            assign prod = a * b;
        end else begin : g_nomul
            assign prod = a;
        end
    endgenerate

    // operation select
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = a << shamt;
            OP_SHR:  y = a >> shamt;
            OP_SRA:  y = $signed(a) >>> shamt;
            OP_MUL:  y = prod;
            OP_LOAD: y = ldv;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/scell_stage.sv
// One chained stage: the running result is the first operand. A requested
// multiply (or an earlier one) freezes the value so it reaches the output
// untouched; the halt flag ripples forward.
module scell_stage
    import scell_pkg::*;
(
    input  stg_cfg_t          cfg,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] ext,
    input  logic              halt_in,
    output logic [WORD_W-1:0] y,
    output logic              halt_out
);
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] op_y;
    logic              mul_hit;

    assign b        = cfg.b_imm ? WORD_W'(cfg.imm) : ext;
    assign mul_hit  = !cfg.pass && (cfg.op == OP_MUL);
    assign halt_out = halt_in || mul_hit;

    scell_op #(.ALLOW_MUL(1'b0), .ALLOW_LOAD(1'b0)) u_op (
        .op (cfg.op),
        .a  (a),
        .b  (b),
        .ld ('0),
        .y  (op_y)
    );

    assign y = (halt_out || cfg.pass) ? a : op_y;
endmodule

// File: rtl/scell_tail.sv
// End-of-cell units: branch test on the final value and the three-operand
// array store (base, index from the chain, value). Both are suppressed
// while a multiply is deferred.
module scell_tail
    import scell_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] res,
    input  logic              halt,
    input  logic [1:0]        br_cond,
    input  logic              st_en,
    input  logic [WORD_W-1:0] st_base,
    output logic              br_take,
    output logic              st_fire,
    output logic [WORD_W-1:0] st_addr
);
    logic cond_met;

    // branch condition decode
    always_comb begin
        case (br_cond)
            BR_EQZ:  cond_met = (res == '0);
            BR_NEZ:  cond_met = (res != '0);
            BR_NEG:  cond_met = res[WORD_W-1];
            default: cond_met = 1'b0;
        endcase
    end

    assign br_take = valid && !halt && cond_met;
    assign st_fire = valid && !halt && st_en;
    assign st_addr = st_base + res;
endmodule

// File: rtl/scell_top.sv
// Stack-chained cell: front stage (ALU, shifter, multiplier, load), six
// chained stages, branch and store tail, one output register stage.
// Assumes cfg_i is stable while valid_i is high.
module scell_top
    import scell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [WORD_W-1:0] opnd_a_i,
    input  logic [WORD_W-1:0] opnd_b_i,
    input  logic [EXT_W-1:0]  ext_i,
    input  logic [WORD_W-1:0] ld_data_i,
    input  logic [WORD_W-1:0] st_base_i,
    input  logic [WORD_W-1:0] st_value_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] result_o,
    output logic              mul_pend_o,
    output logic              br_taken_o,
    output logic              st_valid_o,
    output logic [WORD_W-1:0] st_addr_o,
    output logic [WORD_W-1:0] st_data_o
);
    cell_cfg_t         cfg;
    logic [WORD_W-1:0] stage_v [STAGES];
    logic              halt    [STAGES];
    logic [WORD_W-1:0] front_b;
    logic [WORD_W-1:0] front_y;
    logic              br_next;
    logic              st_next;
    logic [WORD_W-1:0] addr_next;

    assign cfg = cell_cfg_t'(cfg_i);

    // front stage: operands as popped from the stack
    assign front_b = cfg.stg[0].b_imm ? WORD_W'(cfg.stg[0].imm) : opnd_b_i;

    scell_op #(.ALLOW_MUL(1'b1), .ALLOW_LOAD(1'b1)) u_front (
        .op (cfg.stg[0].op),
        .a  (opnd_a_i),
        .b  (front_b),
        .ld (ld_data_i),
        .y  (front_y)
    );

    assign stage_v[0] = cfg.stg[0].pass ? opnd_a_i : front_y;
    assign halt[0]    = 1'b0;

    // chained stages, each fed by its predecessor
    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_chain
            scell_stage u_stg (
                .cfg      (cfg.stg[k]),
                .a        (stage_v[k-1]),
                .ext      (ext_i[(k-1)*WORD_W +: WORD_W]),
                .halt_in  (halt[k-1]),
                .y        (stage_v[k]),
                .halt_out (halt[k])
            );
        end
    endgenerate

    scell_tail u_tail (
        .valid   (valid_i),
        .res     (stage_v[STAGES-1]),
        .halt    (halt[STAGES-1]),
        .br_cond (cfg.br),
        .st_en   (cfg.st_en),
        .st_base (st_base_i),
        .br_take (br_next),
        .st_fire (st_next),
        .st_addr (addr_next)
    );

    // output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            result_o   <= '0;
            mul_pend_o <= 1'b0;
            br_taken_o <= 1'b0;
            st_valid_o <= 1'b0;
            st_addr_o  <= '0;
            st_data_o  <= '0;
        end else begin
            valid_o    <= valid_i;
            result_o   <= stage_v[STAGES-1];
            mul_pend_o <= valid_i && halt[STAGES-1];
            br_taken_o <= br_next;
            st_valid_o <= st_next;
            st_addr_o  <= addr_next;
            st_data_o  <= st_value_i;
        end
    end
endmodule

// File: rtl/scell_chk.sv
// Property checker for scell_top, attached by bind. Decodes the
// configuration on its own and relates it to the registered outputs.
module scell_chk
    import scell_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [CFG_W-1:0]  cfg_i,
    input logic [WORD_W-1:0] opnd_a_i,
    input logic [WORD_W-1:0] st_value_i,
    input logic              valid_o,
    input logic [WORD_W-1:0] result_o,
    input logic              mul_pend_o,
    input logic              br_taken_o,
    input logic              st_valid_o,
    input logic [WORD_W-1:0] st_data_o
);
    cell_cfg_t c;
    logic      chain_mul;
    logic      all_pass;
    logic      unused_bits;

    assign c           = cell_cfg_t'(cfg_i);
    assign unused_bits = ^cfg_i;

    // independent decode of deferred multiply and full pass-through
    always_comb begin
        chain_mul = 1'b0;
        all_pass  = 1'b1;
        for (int k = 0; k < STAGES; k++) begin
            if (!c.stg[k].pass) all_pass = 1'b0;
            if (k > 0 && !c.stg[k].pass && c.stg[k].op == OP_MUL) chain_mul = 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !mul_pend_o && !br_taken_o && !st_valid_o));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (valid_o == $past(valid_i)));

    p_all_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && all_pass) |=> (result_o == $past(opnd_a_i)));

    p_mul_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && chain_mul) |=> mul_pend_o);

    p_mul_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !chain_mul) |=> !mul_pend_o);

    p_br_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_o |-> (valid_o && !mul_pend_o));

    p_st_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o |-> (valid_o && !mul_pend_o));

    p_st_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (st_data_o == $past(st_value_i)));
endmodule

bind scell_top scell_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .cfg_i      (cfg_i),
    .opnd_a_i   (opnd_a_i),
    .st_value_i (st_value_i),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .mul_pend_o (mul_pend_o),
    .br_taken_o (br_taken_o),
    .st_valid_o (st_valid_o),
    .st_data_o  (st_data_o)
);

// File: tb/scell_top_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps front opcode x chain opcode x chain position,
// then random and directed cases, against an arithmetic reference.
module scell_top_bench;
    import scell_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              valid_i;
    logic [CFG_W-1:0]  cfg_i;
    logic [WORD_W-1:0] opnd_a_i, opnd_b_i, ld_data_i, st_base_i, st_value_i;
    logic [EXT_W-1:0]  ext_i;
    logic              valid_o, mul_pend_o, br_taken_o, st_valid_o;
    logic [WORD_W-1:0] result_o, st_addr_o, st_data_o;
    logic [31:0]       ext_arr [CHAIN_LEN];

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < CHAIN_LEN; k++) ext_i[k*32 +: 32] = ext_arr[k];
    end

    scell_top u_scell_top (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cfg_i(cfg_i),
        .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .ext_i(ext_i),
        .ld_data_i(ld_data_i), .st_base_i(st_base_i), .st_value_i(st_value_i),
        .valid_o(valid_o), .result_o(result_o), .mul_pend_o(mul_pend_o),
        .br_taken_o(br_taken_o), .st_valid_o(st_valid_o),
        .st_addr_o(st_addr_o), .st_data_o(st_data_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_op(input logic [3:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [31:0] ld,
                                           input bit front);
        logic [4:0] s;
        s = b[4:0];
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << s;
            4'd6: return a >> s;
            4'd7: return 32'($signed(a) >>> s);
            4'd8: return front ? 32'(a * b) : a;
            4'd9: return front ? ld : a;
            default: return a;
        endcase
    endfunction

    function automatic cell_cfg_t rand_cfg();
        cell_cfg_t c;
        c = cell_cfg_t'('0);
        for (int k = 0; k < STAGES; k++) begin
            c.stg[k].op    = 4'($urandom_range(0, 15));
            c.stg[k].pass  = ($urandom_range(0, 3) == 0);
            c.stg[k].b_imm = $urandom_range(0, 1);
            c.stg[k].imm   = 8'($urandom);
        end
        c.br    = 2'($urandom_range(0, 3));
        c.st_en = $urandom_range(0, 1);
        return c;
    endfunction

    // drive one operation on a falling edge, check one edge later
    task automatic apply(input logic [CFG_W-1:0] raw, input logic [31:0] a,
                         input logic [31:0] b, input string rtag);
        cell_cfg_t   c;
        logic [31:0] v, sb, ld, base, val;
        bit          halt, brt, cond;
        c    = cell_cfg_t'(raw);
        ld   = $urandom;
        base = $urandom;
        val  = $urandom;
        sb   = c.stg[0].b_imm ? 32'(c.stg[0].imm) : b;
        v    = c.stg[0].pass ? a : ref_op(c.stg[0].op, a, sb, ld, 1'b1);
        halt = 1'b0;
        for (int k = 1; k < STAGES; k++) begin
            sb = c.stg[k].b_imm ? 32'(c.stg[k].imm) : ext_arr[k-1];
            if (!halt && !c.stg[k].pass) begin
                if (c.stg[k].op == 4'd8) halt = 1'b1;
                else v = ref_op(c.stg[k].op, v, sb, ld, 1'b0);
            end
        end
        case (c.br)
            2'd1: cond = (v == 0);
            2'd2: cond = (v != 0);
            2'd3: cond = v[31];
            default: cond = 1'b0;
        endcase
        brt = cond && !halt;
        @(negedge clk);
        valid_i = 1'b1; cfg_i = raw; opnd_a_i = a; opnd_b_i = b;
        ld_data_i = ld; st_base_i = base; st_value_i = val;
        @(negedge clk);
        chk("R2", "valid", 32'(valid_o), 32'd1);
        chk(rtag, "result", result_o, v);
        chk("R7", "mul_pend", 32'(mul_pend_o), 32'(halt));
        chk("R8", "branch", 32'(br_taken_o), 32'(brt));
        chk("R9", "st_valid", 32'(st_valid_o), 32'(c.st_en && !halt));
        chk("R9", "st_addr", st_addr_o, base + v);
        chk("R9", "st_data", st_data_o, val);
    endtask

    function automatic cell_cfg_t all_pass_cfg();
        cell_cfg_t c;
        c = cell_cfg_t'('0);
        for (int k = 0; k < STAGES; k++) c.stg[k].pass = 1'b1;
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cell_cfg_t c;
        logic [CFG_W-1:0] raw;
        rst_n = 1'b0; valid_i = 1'b1; cfg_i = '1;
        opnd_a_i = 32'h5; opnd_b_i = 32'h7; ld_data_i = '0;
        st_base_i = '0; st_value_i = 32'h1234;
        for (int k = 0; k < CHAIN_LEN; k++) ext_arr[k] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "valid", 32'(valid_o), 0);
        chk("R1", "mul_pend", 32'(mul_pend_o), 0);
        chk("R1", "branch", 32'(br_taken_o), 0);
        chk("R1", "st_valid", 32'(st_valid_o), 0);
        chk("R1", "result", result_o, 0);
        chk("R1", "st_data", st_data_o, 0);
        rst_n = 1'b1;

        // R4/R7 sweep: every front op against every chain op at each position
        for (int fop = 0; fop < 16; fop++)
            for (int cop = 0; cop < 16; cop++)
                for (int pos = 1; pos < STAGES; pos++) begin
                    c = rand_cfg();
                    c.stg[0].op = 4'(fop); c.stg[0].pass = 1'b0;
                    c.stg[pos].op = 4'(cop); c.stg[pos].pass = 1'b0;
                    for (int k = 0; k < CHAIN_LEN; k++) ext_arr[k] = $urandom;
                    apply(c, $urandom, $urandom, (cop == 8) ? "R7" : "R4");
                end

        // random configurations
        for (int i = 0; i < 600; i++) begin
            for (int k = 0; k < CHAIN_LEN; k++) ext_arr[k] = $urandom;
            apply(rand_cfg(), $urandom, $urandom, "R4");
        end

        // R3: front multiply and load
        c = all_pass_cfg(); c.stg[0].pass = 1'b0; c.stg[0].op = 4'd8;
        apply(c, 32'd7, 32'd6, "R3");
        chk("R3", "front mul literal", result_o, 32'd42);
        c.stg[0].op = 4'd9;
        apply(c, 32'd7, 32'd6, "R3");
        chk("R3", "front load equals ld_data", result_o, ld_data_i);

        // R5: shift amount uses low 5 bits
        c.stg[0].op = 4'd5;
        apply(c, 32'd1, 32'd37, "R5");
        chk("R5", "shl by 37", result_o, 32'd32);
        c.stg[0].op = 4'd7;
        apply(c, 32'h8000_0000, 32'd4, "R5");
        chk("R5", "sra", result_o, 32'hF800_0000);

        // R6: everything passed
        c = all_pass_cfg(); c.stg[3].op = 4'd1; c.stg[0].op = 4'd0;
        apply(c, 32'hCAFE_0001, 32'd9, "R6");
        chk("R6", "all pass literal", result_o, 32'hCAFE_0001);

        // R7: multiply at stage 1 freezes the front value; later adds ignored
        c = all_pass_cfg(); c.stg[0].pass = 1'b0; c.stg[0].op = 4'd0;
        c.stg[1].pass = 1'b0; c.stg[1].op = 4'd8;
        c.stg[2].pass = 1'b0; c.stg[2].op = 4'd0; c.stg[2].b_imm = 1'b1; c.stg[2].imm = 8'd50;
        c.br = 2'd2; c.st_en = 1'b1;
        apply(c, 32'd3, 32'd4, "R7");
        chk("R7", "frozen value", result_o, 32'd7);
        chk("R7", "pending", 32'(mul_pend_o), 1);
        chk("R8", "branch held off", 32'(br_taken_o), 0);
        chk("R9", "store held off", 32'(st_valid_o), 0);

        // R8: branch conditions on literal results
        c = all_pass_cfg(); c.stg[0].pass = 1'b0; c.stg[0].op = 4'd1; c.br = 2'd1;
        apply(c, 32'd9, 32'd9, "R8");
        chk("R8", "eqz taken", 32'(br_taken_o), 1);
        c.br = 2'd3;
        apply(c, 32'd1, 32'd2, "R8");
        chk("R8", "neg taken", 32'(br_taken_o), 1);
        c.br = 2'd0;
        apply(c, 32'd1, 32'd2, "R8");
        chk("R8", "never", 32'(br_taken_o), 0);

        // R10: raw bit layout, front add immediate 5, branch nez, store on
        raw = '0;
        for (int s = 0; s < STAGES; s++) raw[3 + 14*s + 9] = 1'b1;
        raw[3 + 9] = 1'b0;
        raw[3 + 8] = 1'b1;
        raw[3 + 7 -: 8] = 8'd5;
        raw[2:1] = 2'd2;
        raw[0] = 1'b1;
        apply(raw, 32'd10, 32'd99, "R10");
        chk("R10", "raw result", result_o, 32'd15);
        chk("R10", "raw branch", 32'(br_taken_o), 1);
        chk("R10", "raw store", 32'(st_valid_o), 1);

        // R2: idle cycle clears flags
        @(negedge clk);
        valid_i = 1'b0;
        @(negedge clk);
        chk("R2", "idle valid", 32'(valid_o), 0);
        chk("R2", "idle branch", 32'(br_taken_o), 0);
        chk("R2", "idle store", 32'(st_valid_o), 0);
        chk("R2", "idle mul", 32'(mul_pend_o), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule